// File: doc/BRIEF.md
# Paged Data-Window Address Generator

This block produces the next effective address for register-indirect data accesses. It handles the case where the upper half of a 16-bit data address space is a 32 KB window onto a larger paged memory. It holds two 10-bit page registers, one for the read side and one for the write side. Each side has its own address, mode and enable, so a single operation can read from one page and write to another in the same cycle.

When an increment or decrement steps off the edge of the window, the block moves the page register up or down by one and keeps the address inside the window, so software sees one linear space. A few fixed pages break this rule. At those pages the address drops into the base space below 0x8000 and the page is held. In the modes that wrap, the address stays inside the current page. The block also raises an address-error trap when a window access uses an illegal page. All results are registered one clock after the request.

Top module: `pw_window_agen`

## Requirements
- R1: After synchronous reset, both page registers read 0x001, and the valid and trap outputs are 0.
- R2: A page load pulse writes the given value into that side's page register at the next clock edge. A load overrides any page update from an access in the same cycle. With neither a load nor an access, the page register is held.
- R3: Mode codes are 0 = plain (address unchanged), 1 = increment, 2 = decrement, 3 = register offset, 4 = modulo, 5 = bit-reversed. Codes 6 and 7 act as plain. Increment and decrement step by 1 when the byte flag is 1 and by 2 otherwise.
- R4: Overflow: the address is in the window (bit 15 = 1) and an increment carries out of bit 15. The page then rises by one and the result is the 16-bit sum with bit 15 forced to 1.
- R5: Underflow: the address is in the window and a decrement lands below 0x8000. The page then falls by one and bit 15 of the result is forced to 1.
- R6: In modes 3, 4 and 5 the result is the externally computed alternate address. If the base address is in the window and the alternate address is below 0x8000, bit 15 is forced to 1 and the page is unchanged.
- R7: On the read side, an overflow from page 0x1FF or from page 0x3FF holds the page and leaves bit 15 clear, so the result lies in base space.
- R8: On the read side, an underflow from page 0x001 or from page 0x200 holds the page and leaves bit 15 clear.
- R9: On the write side, an overflow from page 0x1FF and an underflow from page 0x001 hold the page and leave bit 15 clear.
- R10: A base address below 0x8000 uses plain 16-bit modular arithmetic and never changes the page.
- R11: A trap is raised in these cases, and the page is then not changed by the access (the result address is still reported):
  - a read-side access with a window address and read page 0x000;
  - a write-side access with a window address and a write page of 0x000 or of 0x200 and above.
- R12: The read and write sides operate independently in the same cycle, each with its own page register.
- R13: Results appear one clock after an enabled request. The trap lasts one cycle per request. The base flag is 1 exactly when the result has bit 15 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read-side request |
| rd_mode | input | 3 | Read-side addressing mode |
| rd_byte | input | 1 | Read-side byte access (step 1) |
| rd_addr | input | 16 | Read-side base address |
| rd_alt | input | 16 | Read-side alternate address for modes 3 to 5 |
| rd_pg_ld | input | 1 | Load read page register |
| rd_pg_val | input | 10 | Read page load value |
| wr_en | input | 1 | Write-side request |
| wr_mode | input | 3 | Write-side addressing mode |
| wr_byte | input | 1 | Write-side byte access |
| wr_addr | input | 16 | Write-side base address |
| wr_alt | input | 16 | Write-side alternate address |
| wr_pg_ld | input | 1 | Load write page register |
| wr_pg_val | input | 10 | Write page load value |
| rd_vld_o | output | 1 | Read result valid |
| rd_ea_o | output | 16 | Read-side next effective address |
| rd_base_o | output | 1 | Read result lies in base space |
| rd_trap_o | output | 1 | Read-side address-error trap |
| rd_page_o | output | 10 | Read page register |
| wr_vld_o | output | 1 | Write result valid |
| wr_ea_o | output | 16 | Write-side next effective address |
| wr_base_o | output | 1 | Write result lies in base space |
| wr_trap_o | output | 1 | Write-side address-error trap |
| wr_page_o | output | 10 | Write page register |

## Verification
Some properties are checked by assertions on every cycle:
- the reset value of the pages;
- idle holding and load priority;
- a page never moving by more than one;
- a page that moves always leaving the result inside the window;
- the wrapping modes never touching the page;
- the trap firing for illegal pages.

The exact result addresses are shown only by the bench's scenarios, which compare against a rule-based model. These include the fixed exception pages 0x1FF, 0x3FF, 0x001 and 0x200 falling into base space, the general carries across 0x2FF/0x300, and the write side ignoring the read-only exception pages.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN = 3'd0,
    AM_INC   = 3'd1,
    AM_DEC   = 3'd2,
    AM_OFFS  = 3'd3,
    AM_MOD   = 3'd4,
    AM_BREV  = 3'd5
  } am_t;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/pw_lane_calc.sv
module pw_lane_calc #(
  parameter int unsigned AW         = 16,
  parameter int unsigned PW         = 10,
  parameter bit          IS_WR      = 1'b0,
  parameter logic [9:0]  EXT_LAST   = 10'h1FF,
  parameter logic [9:0]  PS_FIRST   = 10'h200,
  parameter logic [9:0]  PS_LAST    = 10'h3FF
) (
  input  logic [2:0]    mode,
  input  logic          byte_acc,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] alt,
  input  logic [PW-1:0] page,
  output logic [AW-1:0] nxt_ea,
  output logic [PW-1:0] nxt_page,
  output logic          trap
);
  import pw_pkg::*;

  localparam logic [AW-1:0] WIN_BIT = {1'b1, {(AW-1){1'b0}}};
  localparam logic [PW-1:0] PG_ONE  = {{(PW-1){1'b0}}, 1'b1};

  logic          win;
  logic [AW:0]   step, sum, dif;
  logic [AW-1:0] raw;
  logic          ovf, unf, wrap;
  logic          ovf_hold, unf_hold;

  assign win  = addr[AW-1];
  assign step = byte_acc ? (AW+1)'(1) : (AW+1)'(2);
  assign sum  = {1'b0, addr} + step;
  assign dif  = {1'b0, addr} - step;

  always_comb begin
    raw  = addr;
    ovf  = 1'b0;
    unf  = 1'b0;
    wrap = 1'b0;
    case (am_t'(mode))
      AM_INC: begin
        raw = sum[AW-1:0];
        ovf = win & sum[AW];
      end
      AM_DEC: begin
        raw = dif[AW-1:0];
        unf = win & ~dif[AW-1];
      end
      AM_OFFS, AM_MOD, AM_BREV: begin
        raw  = alt;
        wrap = win & ~alt[AW-1];
      end
      default: raw = addr;
    endcase
  end

  generate
    if (IS_WR) begin : g_wr_rules
      assign ovf_hold = (page == PW'(EXT_LAST));
      assign unf_hold = (page == PG_ONE);
      assign trap     = win & ((page == '0) | (page >= PW'(PS_FIRST)));
    end else begin : g_rd_rules
      assign ovf_hold = (page == PW'(EXT_LAST)) | (page == PW'(PS_LAST));
      assign unf_hold = (page == PG_ONE) | (page == PW'(PS_FIRST));
      assign trap     = win & (page == '0);
    end
  endgenerate

  always_comb begin
    nxt_ea   = raw;
    nxt_page = page;
    if (ovf && !ovf_hold) begin
      nxt_ea   = raw | WIN_BIT;
      nxt_page = page + PG_ONE;
    end else if (unf && !unf_hold) begin
      nxt_ea   = raw | WIN_BIT;
      nxt_page = page - PG_ONE;
    end else if (wrap) begin
      nxt_ea   = raw | WIN_BIT;
    end
    if (trap) nxt_page = page;
  end
endmodule

// File: rtl/pw_lane_state.sv
module pw_lane_state #(
  parameter int unsigned AW       = 16,
  parameter int unsigned PW       = 10,
  parameter logic [9:0]  PAGE_RST = 10'h001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ld,
  input  logic [PW-1:0] ld_val,
  input  logic [AW-1:0] nxt_ea,
  input  logic [PW-1:0] nxt_page,
  input  logic          trap_in,
  output logic [PW-1:0] page_q,
  output logic          vld_q,
  output logic [AW-1:0] ea_q,
  output logic          base_q,
  output logic          trap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PW'(PAGE_RST);
      vld_q  <= 1'b0;
      ea_q   <= '0;
      base_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      vld_q  <= en;
      trap_q <= en & trap_in;
      if (en) begin
        ea_q   <= nxt_ea;
        base_q <= ~nxt_ea[AW-1];
      end
      if (ld)      page_q <= ld_val;
      else if (en) page_q <= nxt_page;
    end
  end
endmodule

// File: rtl/pw_window_agen.sv
module pw_window_agen #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [2:0]    rd_mode,
  input  logic          rd_byte,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_alt,
  input  logic          rd_pg_ld,
  input  logic [PW-1:0] rd_pg_val,
  input  logic          wr_en,
  input  logic [2:0]    wr_mode,
  input  logic          wr_byte,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_alt,
  input  logic          wr_pg_ld,
  input  logic [PW-1:0] wr_pg_val,
  output logic          rd_vld_o,
  output logic [AW-1:0] rd_ea_o,
  output logic          rd_base_o,
  output logic          rd_trap_o,
  output logic [PW-1:0] rd_page_o,
  output logic          wr_vld_o,
  output logic [AW-1:0] wr_ea_o,
  output logic          wr_base_o,
  output logic          wr_trap_o,
  output logic [PW-1:0] wr_page_o
);
  import pw_pkg::*;

  logic          s_en   [NUM_SIDES];
  logic [2:0]    s_mode [NUM_SIDES];
  logic          s_byte [NUM_SIDES];
  logic [AW-1:0] s_addr [NUM_SIDES];
  logic [AW-1:0] s_alt  [NUM_SIDES];
  logic          s_ld   [NUM_SIDES];
  logic [PW-1:0] s_ldv  [NUM_SIDES];
  logic [AW-1:0] s_nea  [NUM_SIDES];
  logic [PW-1:0] s_npg  [NUM_SIDES];
  logic          s_trp  [NUM_SIDES];
  logic [PW-1:0] s_pg   [NUM_SIDES];
  logic          s_vld  [NUM_SIDES];
  logic [AW-1:0] s_ea   [NUM_SIDES];
  logic          s_base [NUM_SIDES];
  logic          s_trq  [NUM_SIDES];

  assign s_en[0]   = rd_en;     assign s_en[1]   = wr_en;
  assign s_mode[0] = rd_mode;   assign s_mode[1] = wr_mode;
  assign s_byte[0] = rd_byte;   assign s_byte[1] = wr_byte;
  assign s_addr[0] = rd_addr;   assign s_addr[1] = wr_addr;
  assign s_alt[0]  = rd_alt;    assign s_alt[1]  = wr_alt;
  assign s_ld[0]   = rd_pg_ld;  assign s_ld[1]   = wr_pg_ld;
  assign s_ldv[0]  = rd_pg_val; assign s_ldv[1]  = wr_pg_val;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    pw_lane_calc #(
      .AW(AW), .PW(PW), .IS_WR(g == 1)
    ) u_calc (
      .mode     (s_mode[g]),
      .byte_acc (s_byte[g]),
      .addr     (s_addr[g]),
      .alt      (s_alt[g]),
      .page     (s_pg[g]),
      .nxt_ea   (s_nea[g]),
      .nxt_page (s_npg[g]),
      .trap     (s_trp[g])
    );

    pw_lane_state #(
      .AW(AW), .PW(PW)
    ) u_state (
      .clk      (clk),
      .rst      (rst),
      .en       (s_en[g]),
      .ld       (s_ld[g]),
      .ld_val   (s_ldv[g]),
      .nxt_ea   (s_nea[g]),
      .nxt_page (s_npg[g]),
      .trap_in  (s_trp[g]),
      .page_q   (s_pg[g]),
      .vld_q    (s_vld[g]),
      .ea_q     (s_ea[g]),
      .base_q   (s_base[g]),
      .trap_q   (s_trq[g])
    );
  end

  assign rd_vld_o  = s_vld[0];  assign wr_vld_o  = s_vld[1];
  assign rd_ea_o   = s_ea[0];   assign wr_ea_o   = s_ea[1];
  assign rd_base_o = s_base[0]; assign wr_base_o = s_base[1];
  assign rd_trap_o = s_trq[0];  assign wr_trap_o = s_trq[1];
  assign rd_page_o = s_pg[0];   assign wr_page_o = s_pg[1];
endmodule

// File: rtl/pw_window_agen_chk.sv
module pw_window_agen_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic [2:0]    rd_mode,
  input logic [AW-1:0] rd_addr,
  input logic          rd_pg_ld,
  input logic [PW-1:0] rd_pg_val,
  input logic          wr_en,
  input logic [2:0]    wr_mode,
  input logic [AW-1:0] wr_addr,
  input logic          wr_pg_ld,
  input logic          rd_vld_o,
  input logic [AW-1:0] rd_ea_o,
  input logic          rd_trap_o,
  input logic [PW-1:0] rd_page_o,
  input logic          wr_vld_o,
  input logic [AW-1:0] wr_ea_o,
  input logic          wr_trap_o,
  input logic [PW-1:0] wr_page_o
);
  localparam logic [PW-1:0] P1   = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] PS_0 = PW'(10'h200);

  AST_RESET_PAGE: assert property (@(posedge clk) rst |=> (rd_page_o == P1 && wr_page_o == P1)); // R1
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!rd_en && !rd_pg_ld) |=> $stable(rd_page_o)); // R2
  AST_WR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!wr_en && !wr_pg_ld) |=> $stable(wr_page_o)); // R2
  AST_RD_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) rd_pg_ld |=> (rd_page_o == $past(rd_pg_val))); // R2
  AST_RD_STEP_ONE: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_pg_ld) |=> (rd_page_o == $past(rd_page_o) || rd_page_o == $past(rd_page_o) + P1 || rd_page_o == $past(rd_page_o) - P1)); // R4
  AST_RD_MOVE_IN_WIN: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_pg_ld) |=> (rd_page_o == $past(rd_page_o) || rd_ea_o[AW-1])); // R5
  AST_WR_MOVE_IN_WIN: assert property (@(posedge clk) disable iff (rst) (wr_en && !wr_pg_ld) |=> (wr_page_o == $past(wr_page_o) || wr_ea_o[AW-1])); // R5
  AST_RD_WRAP_KEEPS: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_pg_ld && rd_mode inside {3'd3, 3'd4, 3'd5}) |=> $stable(rd_page_o)); // R6
  AST_WR_WRAP_KEEPS: assert property (@(posedge clk) disable iff (rst) (wr_en && !wr_pg_ld && wr_mode inside {3'd3, 3'd4, 3'd5}) |=> $stable(wr_page_o)); // R6
  AST_RD_PAGE0_TRAP: assert property (@(posedge clk) disable iff (rst) (rd_en && rd_addr[AW-1] && rd_page_o == '0) |=> rd_trap_o); // R11
  AST_WR_PS_TRAP: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr[AW-1] && wr_page_o >= PS_0) |=> wr_trap_o); // R11
  AST_RD_TRAP_VALID: assert property (@(posedge clk) disable iff (rst) rd_trap_o |-> rd_vld_o); // R13
  AST_WR_TRAP_VALID: assert property (@(posedge clk) disable iff (rst) wr_trap_o |-> wr_vld_o); // R13
endmodule

bind pw_window_agen pw_window_agen_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/pw_window_agen_bench.sv
module pw_window_agen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 0, rd_byte = 0, rd_pg_ld = 0;
  logic [2:0]  rd_mode = 0;
  logic [15:0] rd_addr = 0, rd_alt = 0;
  logic [9:0]  rd_pg_val = 0;
  logic        wr_en = 0, wr_byte = 0, wr_pg_ld = 0;
  logic [2:0]  wr_mode = 0;
  logic [15:0] wr_addr = 0, wr_alt = 0;
  logic [9:0]  wr_pg_val = 0;
  logic        rd_vld_o, rd_base_o, rd_trap_o, wr_vld_o, wr_base_o, wr_trap_o;
  logic [15:0] rd_ea_o, wr_ea_o;
  logic [9:0]  rd_page_o, wr_page_o;

  int checks = 0;
  int failures = 0;
  int m_rpg = 1;
  int m_wpg = 1;
  bit done = 0;

  always #10 clk = ~clk;

  pw_window_agen u_pw_window_agen (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_side(input bit wr, input int mode, input bit byt,
                                   input int a, input int alt, input int pg,
                                   output int ea, output int npg, output bit trp);
    int st;
    bit win;
    st  = byt ? 1 : 2;
    win = (a >= 32768);
    ea  = a;
    npg = pg;
    trp = win && (pg == 0 || (wr && pg >= 512));
    if (mode == 1) begin
      ea = a + st;
      if (ea > 65535) begin
        ea -= 65536;
        if (win && !(pg == 511 || (!wr && pg == 1023))) begin
          ea += 32768;
          npg = (pg + 1) % 1024;
        end
      end
    end else if (mode == 2) begin
      ea = a - st;
      if (ea < 0) ea += 65536;
      if (win && ea < 32768 && !(pg == 1 || (!wr && pg == 512))) begin
        ea += 32768;
        npg = (pg + 1023) % 1024;
      end
    end else if (mode >= 3 && mode <= 5) begin
      ea = alt;
      if (win && alt < 32768) ea += 32768;
    end
    if (trp) npg = pg;
  endfunction

  // Apply current inputs across one edge and compare against the model.
  task automatic run_cycle(input string tag);
    int rea, rpg, wea, wpg;
    bit rtr, wtr;
    ref_side(0, rd_mode, rd_byte, rd_addr, rd_alt, m_rpg, rea, rpg, rtr);
    ref_side(1, wr_mode, wr_byte, wr_addr, wr_alt, m_wpg, wea, wpg, wtr);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R13 rd_vld"}, rd_vld_o, rd_en);
    chk({tag, " R13 wr_vld"}, wr_vld_o, wr_en);
    chk({tag, " R11 rd_trap"}, rd_trap_o, rd_en & rtr);
    chk({tag, " R11 wr_trap"}, wr_trap_o, wr_en & wtr);
    if (rd_en) begin
      chk({tag, " rd_ea"}, rd_ea_o, rea);
      chk({tag, " R13 rd_base"}, rd_base_o, rea < 32768);
    end
    if (wr_en) begin
      chk({tag, " wr_ea"}, wr_ea_o, wea);
      chk({tag, " R13 wr_base"}, wr_base_o, wea < 32768);
    end
    if (rd_pg_ld) m_rpg = rd_pg_val; else if (rd_en) m_rpg = rpg;
    if (wr_pg_ld) m_wpg = wr_pg_val; else if (wr_en) m_wpg = wpg;
    chk({tag, " R2 rd_page"}, rd_page_o, m_rpg);
    chk({tag, " R2 wr_page"}, wr_page_o, m_wpg);
  endtask

  task automatic load_pages(input int rp, input int wp);
    rd_en = 0; wr_en = 0;
    rd_pg_ld = 1; rd_pg_val = rp[9:0];
    wr_pg_ld = 1; wr_pg_val = wp[9:0];
    run_cycle("R2 load");
    rd_pg_ld = 0; wr_pg_ld = 0;
  endtask

  task automatic rd_req(input int mode, input bit byt, input int a, input int alt);
    rd_en = 1; rd_mode = mode[2:0]; rd_byte = byt; rd_addr = a[15:0]; rd_alt = alt[15:0];
  endtask

  task automatic wr_req(input int mode, input bit byt, input int a, input int alt);
    wr_en = 1; wr_mode = mode[2:0]; wr_byte = byt; wr_addr = a[15:0]; wr_alt = alt[15:0];
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0;
  endtask

  function automatic int pick_page();
    int sel;
    sel = $urandom_range(0, 12);
    case (sel)
      0: return 0;      1: return 1;      2: return 2;
      3: return 'h1FE;  4: return 'h1FF;  5: return 'h200;
      6: return 'h201;  7: return 'h2FF;  8: return 'h300;
      9: return 'h3FE;  10: return 'h3FF;
      default: return $urandom_range(0, 1023);
    endcase
  endfunction

  function automatic int pick_addr();
    int sel;
    sel = $urandom_range(0, 5);
    case (sel)
      0: return $urandom_range(16'hFFFC, 16'hFFFF);
      1: return $urandom_range(16'h8000, 16'h8003);
      2: return $urandom_range(16'h7FFC, 16'h7FFF);
      3: return $urandom_range(0, 3);
      default: return $urandom_range(0, 65535);
    endcase
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    @(negedge clk);
    @(negedge clk);
    chk("R1 rd_page reset", rd_page_o, 1);
    chk("R1 wr_page reset", wr_page_o, 1);
    chk("R1 rd_vld reset", rd_vld_o, 0);
    chk("R1 rd_trap reset", rd_trap_o, 0);
    chk("R1 wr_trap reset", wr_trap_o, 0);
    rst = 0;
    @(negedge clk);

    // R3 / R10: base space arithmetic, plain mode, page untouched
    rd_req(1, 1, 'h1234, 0); wr_req(2, 0, 'h0000, 0);
    run_cycle("R3 R10 base step");
    rd_req(0, 0, 'h9ABC, 0); wr_req(7, 0, 'h8888, 0);
    run_cycle("R3 plain");
    rd_req(1, 0, 'h7FFF, 0); wr_req(1, 1, 'h7FFF, 0);
    run_cycle("R10 no carry below window");
    idle();

    // R4 general overflow
    load_pages('h2FF, 'h010);
    rd_req(1, 0, 'hFFFF, 0); wr_req(1, 0, 'hFFFE, 0);
    run_cycle("R4 overflow 2FF->300");
    chk("R4 rd page after", rd_page_o, 'h300);
    chk("R4 rd ea after", rd_ea_o, 'h8001);

    // R5 general underflow
    rd_req(2, 0, 'h8000, 0); wr_req(2, 1, 'h8000, 0);
    run_cycle("R5 underflow 300->2FF");
    chk("R5 rd page after", rd_page_o, 'h2FF);
    chk("R5 wr page after", wr_page_o, 'h010);
    idle();

    // R7 read overflow exceptions
    load_pages('h1FF, 'h1FF);
    rd_req(1, 1, 'hFFFF, 0); wr_req(1, 1, 'hFFFF, 0);
    run_cycle("R7 R9 overflow last extended page");
    chk("R7 rd ea base", rd_ea_o, 'h0000);
    chk("R9 wr page held", wr_page_o, 'h1FF);
    idle();
    load_pages('h3FF, 'h100);
    rd_req(1, 0, 'hFFFE, 0); idle(); rd_req(1, 0, 'hFFFE, 0);
    run_cycle("R7 overflow 3FF");
    chk("R7 rd base flag", rd_base_o, 1);
    idle();

    // R8 / R9 underflow exceptions
    load_pages('h001, 'h001);
    rd_req(2, 0, 'h8001, 0); wr_req(2, 0, 'h8001, 0);
    run_cycle("R8 R9 underflow page 1");
    chk("R8 rd ea", rd_ea_o, 'h7FFF);
    idle();
    load_pages('h200, 'h002);
    rd_req(2, 1, 'h8000, 0); wr_req(2, 1, 'h8000, 0);
    run_cycle("R8 underflow 200, write general");
    chk("R8 rd page held", rd_page_o, 'h200);
    chk("R12 wr page moved", wr_page_o, 'h001);
    idle();

    // R6 wrapping modes
    load_pages('h050, 'h060);
    rd_req(3, 0, 'h9000, 'h0040); wr_req(4, 0, 'hC000, 'hA000);
    run_cycle("R6 offset wrap / modulo in window");
    chk("R6 rd ea", rd_ea_o, 'h8040);
    rd_req(5, 0, 'h8000, 'h0002); wr_req(3, 0, 'h1000, 'h0002);
    run_cycle("R6 bitrev wrap / base offset");
    idle();

    // R11 traps, then pulse ends
    load_pages('h000, 'h250);
    rd_req(1, 0, 'hFFFF, 0); wr_req(2, 0, 'h8000, 0);
    run_cycle("R11 trap");
    chk("R11 rd page held", rd_page_o, 0);
    idle();
    run_cycle("R13 trap pulse ends");
    chk("R13 rd trap low", rd_trap_o, 0);
    rd_req(1, 0, 'h1000, 0);
    run_cycle("R11 page 0 base space no trap");

    // R2 load priority over carry
    rd_pg_ld = 1; rd_pg_val = 'h123;
    rd_req(1, 0, 'hFFFF, 0);
    run_cycle("R2 load priority");
    rd_pg_ld = 0;
    idle();

    // Constrained random mix, R12 both sides together
    for (int i = 0; i < 3000; i++) begin
      rd_pg_ld = ($urandom_range(0, 3) == 0);
      wr_pg_ld = ($urandom_range(0, 3) == 0);
      rd_pg_val = pick_page();
      wr_pg_val = pick_page();
      rd_en = ($urandom_range(0, 4) != 0);
      wr_en = ($urandom_range(0, 4) != 0);
      rd_mode = $urandom_range(0, 7);
      wr_mode = $urandom_range(0, 7);
      rd_byte = $urandom_range(0, 1);
      wr_byte = $urandom_range(0, 1);
      rd_addr = pick_addr();
      wr_addr = pick_addr();
      rd_alt = pick_addr();
      wr_alt = pick_addr();
      run_cycle("R12 random");
    end
    rd_pg_ld = 0; wr_pg_ld = 0;
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule